// File: doc/BRIEF.md
# Macro Instruction ALU with Persistent Carry and Bitfield Unit

This block computes the value of one non-branch macro instruction per enabled cycle. It is given the 32-bit instruction word and the two register operand values, already read from the register file by the surrounding sequencer. It returns a registered 32-bit result that the sequencer writes back. Register storage, operand selection and instruction sequencing are outside this block.

The operation class sits in instruction bits 2:0. Register-register operations pick a sub-operation from bits 21:17. That group covers two adds and two subtracts that share one carry flag, which survives from one instruction to the next, and five bitwise operations. The other classes are an add of a sign-extended 18-bit immediate, three bitfield forms, and a read of an external state register. The read uses a combinational request port that returns its data in the same cycle.

Any class or sub-operation code outside the defined set raises an error flag with a zero result.

Top module: `macro_alu_core`

## Requirements
- R1: The result, carry and error outputs are registered. `done` is high in the cycle after `en` was high, and low otherwise. While `en` is low, the result, carry and error outputs hold their values.
- R2: Register-register sub-operation 0 (add) produces A+B. Sub-operation 1 (add with carry) produces A+B+carry. Both set carry to 1 exactly when the 33-bit sum is above 0xFFFFFFFF.
- R3: Sub-operation 2 (subtract) produces A−B. Sub-operation 3 (subtract with borrow) produces A−B−(1−carry). Both set carry to 1 exactly when the exact difference is not negative, that is, when no borrow occurs.
- R4: Sub-operations 8, 9, 10, 11 and 12 produce A XOR B, A OR B, A AND B, A AND NOT B, and NOT (A AND B). The carry flag is unchanged.
- R5: Class 1 (add immediate) produces A plus instruction bits 31:14 sign-extended to 32 bits. The carry flag is unchanged.
- R6: In the bitfield classes the source position is bits 21:17, the size is bits 26:22, the destination position is bits 31:27, and the mask is (1<<size)−1. Class 2 (replace) produces ((B>>src)&mask)<<dst merged into A, with that field of A cleared first.
- R7: Class 3 (extract, immediate destination) produces ((B>>A[4:0])&mask)<<dst. Only the low 5 bits of A are used.
- R8: Class 4 (extract, register shift) produces ((B>>src)&mask)<<A[4:0]. Only the low 5 bits of A are used.
- R9: Class 5 (read immediate) drives `rd_req` high in the same cycle as `en`, with `rd_addr` = A plus the sign-extended immediate. The value returned on `rd_data` becomes the result. `rd_req` is low for every other class.
- R10: Classes 6 and 7, and register-register sub-operations other than 0–3 and 8–12, set `err` and give a zero result. The carry flag is unchanged. Every valid instruction clears `err`.
- R11: After reset, `result`, `carry`, `err` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en | input | 1 | Instruction valid; also the clock enable for the result registers |
| instr | input | 32 | Instruction word |
| opa | input | 32 | Register A value |
| opb | input | 32 | Register B value |
| rd_req | output | 1 | State-read request, same cycle as `en` |
| rd_addr | output | 32 | State-read address |
| rd_data | input | 32 | State-read return data, valid in the request cycle |
| result | output | 32 | Registered instruction result |
| carry | output | 1 | Persistent carry flag |
| err | output | 1 | Invalid class or sub-operation seen on the last enabled instruction |
| done | output | 1 | Result valid strobe, one cycle after `en` |

## Verification
Two things can fall in the same cycle: the carry flag is written by one instruction and read by the next. This happens whenever a carry-producing add or subtract is followed at once by an add with carry or a subtract with borrow. The bench holds `en` high across long runs of random register-register instructions, including operands at the 0 and 0xFFFFFFFF boundaries. Each instruction is judged against a bench model whose carry comes only from the model's own previous step, so a flag that is late by one cycle, or written by a non-arithmetic instruction, shows up as a mismatch.

// File: rtl/macro_alu_pkg.sv
package macro_alu_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned SW = $clog2(DW);

  // Operation class, instruction bits 2:0
  localparam logic [2:0] CLS_REG    = 3'd0;
  localparam logic [2:0] CLS_ADDI   = 3'd1;
  localparam logic [2:0] CLS_BFINS  = 3'd2;
  localparam logic [2:0] CLS_BFXIMM = 3'd3;
  localparam logic [2:0] CLS_BFXREG = 3'd4;
  localparam logic [2:0] CLS_RDIMM  = 3'd5;

  // Register-register sub-operation, instruction bits 21:17
  localparam logic [4:0] SUB_ADD  = 5'd0;
  localparam logic [4:0] SUB_ADDC = 5'd1;
  localparam logic [4:0] SUB_SUB  = 5'd2;
  localparam logic [4:0] SUB_SUBB = 5'd3;
  localparam logic [4:0] SUB_XOR  = 5'd8;
  localparam logic [4:0] SUB_OR   = 5'd9;
  localparam logic [4:0] SUB_AND  = 5'd10;
  localparam logic [4:0] SUB_ANDN = 5'd11;
  localparam logic [4:0] SUB_NAND = 5'd12;

  typedef enum logic [1:0] {
    BF_REPLACE = 2'd0,
    BF_XIMM    = 2'd1,
    BF_XREG    = 2'd2,
    BF_NONE    = 2'd3
  } bf_form_e;

  typedef struct packed {
    logic [DW-1:0] value;
    logic          carry;
    logic          err;
  } alu_out_t;
endpackage

// File: rtl/macro_alu_arith.sv
module macro_alu_arith
  import macro_alu_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         do_sub,
  input  logic         use_cin,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int unsigned XW = W + 1;

  logic [XW-1:0] ext_a;
  logic [XW-1:0] ext_b;
  logic [XW-1:0] ext_c;
  logic [XW-1:0] total;

  always_comb begin
    ext_a = {1'b0, a};
    ext_b = {1'b0, b};
    ext_c = '0;
    if (do_sub) begin
      // borrow-in is the inverse of the stored no-borrow flag
      ext_c[0] = use_cin & ~cin;
      total    = ext_a - ext_b - ext_c;
      cout     = ~total[W];
    end else begin
      ext_c[0] = use_cin & cin;
      total    = ext_a + ext_b + ext_c;
      cout     = total[W];
    end
    sum = total[W-1:0];
  end
endmodule

// File: rtl/macro_alu_logic.sv
module macro_alu_logic
  import macro_alu_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [4:0]   sub,
  output logic [W-1:0] value,
  output logic         hit
);
  always_comb begin
    value = '0;
    hit   = 1'b1;
    case (sub)
      SUB_XOR:  value = a ^ b;
      SUB_OR:   value = a | b;
      SUB_AND:  value = a & b;
      SUB_ANDN: value = a & ~b;
      SUB_NAND: value = ~(a & b);
      default:  hit   = 1'b0;
    endcase
  end
endmodule

// File: rtl/macro_alu_bitfield.sv
module macro_alu_bitfield
  import macro_alu_pkg::*;
#(
  parameter int unsigned W  = DW,
  parameter int unsigned PW = SW
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [PW-1:0] src_pos,
  input  logic [PW-1:0] fld_size,
  input  logic [PW-1:0] dst_pos,
  input  bf_form_e      form,
  output logic [W-1:0]  value
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0]  mask;
  logic [PW-1:0] a_amt;
  logic [W-1:0]  fld_by_imm;
  logic [W-1:0]  fld_by_reg;

  always_comb begin
    mask       = (ONE << fld_size) - ONE;
    a_amt      = a[PW-1:0];
    fld_by_imm = (b >> src_pos) & mask;
    fld_by_reg = (b >> a_amt) & mask;
    case (form)
      BF_REPLACE: value = (fld_by_imm << dst_pos) | (a & ~(mask << dst_pos));
      BF_XIMM:    value = fld_by_reg << dst_pos;
      BF_XREG:    value = fld_by_imm << a_amt;
      default:    value = '0;
    endcase
  end
endmodule

// File: rtl/macro_alu_core.sv
module macro_alu_core
  import macro_alu_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [31:0]   instr,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] result,
  output logic          carry,
  output logic          err,
  output logic          done
);
  localparam int unsigned IMM_W = 18;
  localparam int unsigned EXT_W = DW - IMM_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_ok_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ok_n = rst_pipe[1];

  // field decode
  logic [2:0]    cls;
  logic [4:0]    sub;
  logic [DW-1:0] imm;
  bf_form_e      form;

  assign cls = instr[2:0];
  assign sub = instr[21:17];
  assign imm = {{EXT_W{instr[31]}}, instr[31:14]};

  always_comb begin
    case (cls)
      CLS_BFINS:  form = BF_REPLACE;
      CLS_BFXIMM: form = BF_XIMM;
      CLS_BFXREG: form = BF_XREG;
      default:    form = BF_NONE;
    endcase
  end

  // datapath units
  logic [DW-1:0] ar_sum;
  logic          ar_cout;
  logic [DW-1:0] lg_val;
  logic          lg_hit;
  logic [DW-1:0] bf_val;
  logic [DW-1:0] imm_sum;

  logic          carry_q;
  logic [DW-1:0] res_q;
  logic          err_q;
  logic          done_q;

  macro_alu_arith #(.W(DW)) arith_i (
    .a       (opa),
    .b       (opb),
    .do_sub  (sub[1]),
    .use_cin (sub[0]),
    .cin     (carry_q),
    .sum     (ar_sum),
    .cout    (ar_cout)
  );

  macro_alu_logic #(.W(DW)) logic_i (
    .a     (opa),
    .b     (opb),
    .sub   (sub),
    .value (lg_val),
    .hit   (lg_hit)
  );

  macro_alu_bitfield #(.W(DW), .PW(SW)) bitf_i (
    .a        (opa),
    .b        (opb),
    .src_pos  (instr[21:17]),
    .fld_size (instr[26:22]),
    .dst_pos  (instr[31:27]),
    .form     (form),
    .value    (bf_val)
  );

  assign imm_sum = opa + imm;
  assign rd_req  = en && (cls == CLS_RDIMM);
  assign rd_addr = AW'(imm_sum);

  // next-state
  alu_out_t nxt;

  always_comb begin
    nxt.value = '0;
    nxt.carry = carry_q;
    nxt.err   = 1'b0;
    case (cls)
      CLS_REG: begin
        if (sub[4:2] == 3'b000) begin
          nxt.value = ar_sum;
          nxt.carry = ar_cout;
        end else if (lg_hit) begin
          nxt.value = lg_val;
        end else begin
          nxt.err = 1'b1;
        end
      end
      CLS_ADDI:                          nxt.value = imm_sum;
      CLS_BFINS, CLS_BFXIMM, CLS_BFXREG: nxt.value = bf_val;
      CLS_RDIMM:                         nxt.value = rd_data;
      default:                           nxt.err   = 1'b1;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      res_q   <= '0;
      carry_q <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= en;
      if (en) begin
        res_q   <= nxt.value;
        carry_q <= nxt.carry;
        err_q   <= nxt.err;
      end
    end
  end

  assign result = res_q;
  assign carry  = carry_q;
  assign err    = err_q;
  assign done   = done_q;
endmodule

// File: rtl/macro_alu_chk.sv
module macro_alu_chk (
  input logic        clk,
  input logic        rst_ok_n,
  input logic        en,
  input logic [31:0] instr,
  input logic [31:0] opa,
  input logic [31:0] opb,
  input logic        rd_req,
  input logic [31:0] result,
  input logic        carry,
  input logic        err,
  input logic        done
);
  AST_DONE_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_ok_n)
    en |=> done) else $error("done missing after en"); // R1
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !en |=> !done) else $error("done without en"); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !en |=> ($stable(result) && $stable(carry) && $stable(err))) else $error("outputs moved while idle"); // R1
  AST_XOR_VALUE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (en && instr[2:0] == 3'd0 && instr[21:17] == 5'd8) |=> (result == ($past(opa) ^ $past(opb)))) else $error("xor value"); // R4
  AST_CARRY_KEPT: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (en && (instr[2:0] != 3'd0 || instr[21:19] != 3'd0)) |=> $stable(carry)) else $error("carry changed"); // R10
  AST_READ_GATED: assert property (@(posedge clk) disable iff (!rst_ok_n)
    rd_req |-> (en && instr[2:0] == 3'd5)) else $error("stray read request"); // R9
  AST_BAD_CLASS: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (en && instr[2:1] == 2'b11) |=> (err && result == 32'd0)) else $error("bad class not flagged"); // R10
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_ok_n)
    err |-> (result == 32'd0)) else $error("error with nonzero result"); // R10
endmodule

bind macro_alu_core macro_alu_chk chk_i (
  .clk      (clk),
  .rst_ok_n (rst_ok_n),
  .en       (en),
  .instr    (instr),
  .opa      (opa),
  .opb      (opb),
  .rd_req   (rd_req),
  .result   (result),
  .carry    (carry),
  .err      (err),
  .done     (done)
);

// File: tb/macro_alu_core_tb.sv
`timescale 1ns/1ps
module macro_alu_core_tb_top;
  localparam logic [31:0] RD_XOR = 32'h5A00_00C3;

  logic        clk;
  logic        rst_n;
  logic        en;
  logic [31:0] instr;
  logic [31:0] opa;
  logic [31:0] opb;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic [31:0] rd_data;
  logic [31:0] result;
  logic        carry;
  logic        err;
  logic        done;

  int checks;
  int errors;
  logic        m_carry;
  logic [31:0] lfsr;

  macro_alu_core dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .instr   (instr),
    .opa     (opa),
    .opb     (opb),
    .rd_req  (rd_req),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .result  (result),
    .carry   (carry),
    .err     (err),
    .done    (done)
  );

  assign rd_data = rd_addr ^ RD_XOR;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    lfsr = lfsr * 32'd1664525 + 32'd1013904223;
    return lfsr;
  endfunction

  // reference model written from the requirement text
  task automatic model(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                       input logic cin, output logic [31:0] r, output logic c,
                       output logic e, output string tag);
    logic [63:0] wide;
    logic [63:0] msk;
    logic [31:0] sx;
    int unsigned sp, sz, dp;
    sx = 32'(signed'(ins[31:14]));
    sp = ins[21:17]; sz = ins[26:22]; dp = ins[31:27];
    msk = (64'd1 << sz) - 64'd1;
    r = 32'd0; c = cin; e = 1'b0; tag = "R10";
    case (ins[2:0])
      3'd0: case (ins[21:17])
        5'd0, 5'd1: begin
          tag = "R2";
          wide = {32'd0, a} + {32'd0, b} + ((ins[17] && cin) ? 64'd1 : 64'd0);
          r = wide[31:0]; c = (wide > 64'hFFFF_FFFF);
        end
        5'd2, 5'd3: begin
          tag = "R3";
          wide = {32'd0, a} - {32'd0, b} - ((ins[17] && !cin) ? 64'd1 : 64'd0);
          r = wide[31:0]; c = (wide < 64'h1_0000_0000);
        end
        5'd8:  begin tag = "R4"; r = a ^ b; end
        5'd9:  begin tag = "R4"; r = a | b; end
        5'd10: begin tag = "R4"; r = a & b; end
        5'd11: begin tag = "R4"; r = a & ~b; end
        5'd12: begin tag = "R4"; r = ~(a & b); end
        default: e = 1'b1;
      endcase
      3'd1: begin tag = "R5"; r = a + sx; end
      3'd2: begin
        tag = "R6";
        wide = ((({32'd0, b} >> sp) & msk) << dp) | ({32'd0, a} & ~(msk << dp));
        r = wide[31:0];
      end
      3'd3: begin
        tag = "R7";
        wide = (({32'd0, b} >> (a % 32)) & msk) << dp;
        r = wide[31:0];
      end
      3'd4: begin
        tag = "R8";
        wide = (({32'd0, b} >> sp) & msk) << (a % 32);
        r = wide[31:0];
      end
      3'd5: begin tag = "R9"; r = (a + sx) ^ RD_XOR; end
      default: e = 1'b1;
    endcase
  endtask

  task automatic step(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] er;
    logic ec, ee, rq_ok;
    string tag;
    en = 1'b1; instr = ins; opa = a; opb = b;
    model(ins, a, b, m_carry, er, ec, ee, tag);
    #1;
    rq_ok = (rd_req === (ins[2:0] == 3'd5));
    if (ins[2:0] == 3'd5) begin
      checks++;
      if (rd_addr !== a + 32'(signed'(ins[17:0] == 18'd0 ? ins[31:14] : ins[31:14]))) begin
        errors++;
        $display("FAIL R9 rd_addr actual=%h expected=%h", rd_addr, a + 32'(signed'(ins[31:14])));
      end
    end
    @(negedge clk);
    checks++;
    if (result !== er || carry !== ec || err !== ee || done !== 1'b1 || !rq_ok) begin
      errors++;
      $display("FAIL %s instr=%h a=%h b=%h actual res=%h c=%b e=%b d=%b rq_ok=%b expected res=%h c=%b e=%b d=1",
               tag, ins, a, b, result, carry, err, done, rq_ok, er, ec, ee);
    end
    m_carry = ec;
  endtask

  task automatic idle();
    logic [31:0] r0;
    logic c0, e0;
    r0 = result; c0 = carry; e0 = err;
    en = 1'b0; instr = rnd(); opa = rnd(); opb = rnd();
    @(negedge clk);
    checks++;
    if (result !== r0 || carry !== c0 || err !== e0 || done !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle actual res=%h c=%b e=%b d=%b expected res=%h c=%b e=%b d=0",
               result, carry, err, done, r0, c0, e0);
    end
  endtask

  function automatic logic [31:0] with_cls(input logic [31:0] w, input logic [2:0] c);
    return {w[31:3], c};
  endfunction

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] w, a, b;
    checks = 0; errors = 0; m_carry = 1'b0; lfsr = 32'hACE1_2468;
    rst_n = 1'b0; en = 1'b0; instr = '0; opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (result !== 32'd0 || carry !== 1'b0 || err !== 1'b0 || done !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset actual res=%h c=%b e=%b d=%b expected 0 0 0 0", result, carry, err, done);
    end

    // explicit carry chains, back-to-back
    step(32'h0000_0000, 32'hFFFF_FFFF, 32'h1);             // R2 add sets carry
    step(32'h0002_0000, 32'h0, 32'h0);                     // R2 addc consumes 1
    step(32'h0004_0000, 32'h0, 32'h1);                     // R3 sub borrows, carry 0
    step(32'h0006_0000, 32'h5, 32'h5);                     // R3 subb with borrow-in
    step(32'h0004_0000, 32'h7, 32'h7);                     // R3 sub equal, carry 1
    step(32'h0006_0000, 32'h5, 32'h5);                     // R3 subb no borrow-in
    step(32'h0010_0000, 32'h1234, 32'h00FF);               // R4 xor keeps carry
    step(32'h0000_0006, 32'h1, 32'h1);                     // R10 class 6
    idle(); idle();

    // register-register sweep, all sub-operation codes
    for (int s = 0; s < 32; s++) begin
      for (int k = 0; k < 24; k++) begin
        a = rnd(); b = rnd();
        if (k == 0) begin a = 32'hFFFF_FFFF; b = 32'h1; end
        if (k == 1) begin a = 32'h0; b = 32'h0; end
        if (k == 2) begin a = 32'h0; b = 32'h1; end
        if (k == 3) b = a;
        if (k == 4) begin a = 32'hFFFF_FFFF; b = 32'hFFFF_FFFF; end
        w = rnd();
        w[21:17] = 5'(s);
        step(with_cls(w, 3'd0), a, b);
        if (k == 7) idle();
      end
    end

    // add immediate and read immediate
    for (int k = 0; k < 128; k++) begin
      step(with_cls(rnd(), 3'd1), rnd(), rnd());   // R5
      step(with_cls(rnd(), 3'd5), rnd(), rnd());   // R9
    end

    // bitfield sweeps over size, source and destination
    for (int f = 2; f <= 4; f++) begin
      for (int sz = 0; sz < 32; sz++) begin
        for (int sp = 0; sp < 32; sp += 7) begin
          for (int dp = 0; dp < 32; dp += 9) begin
            w = {5'(dp), 5'(sz), 5'(sp), 14'(rnd()), 3'(f)};
            step(w, rnd(), rnd());   // R6 R7 R8
          end
        end
      end
    end

    // invalid classes
    for (int k = 0; k < 32; k++) begin
      step(with_cls(rnd(), 3'd6), rnd(), rnd());   // R10
      step(with_cls(rnd(), 3'd7), rnd(), rnd());   // R10
    end
    idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule